// File: doc/BRIEF.md
# Port-Select External Interrupt Controller

This block turns edges on general-purpose input pins into sixteen separate interrupt requests. Several input ports feed it, and each port supplies sixteen pins. Interrupt line n can only ever watch pin n. A 4-bit code chosen for each line names the one port whose pin n drives that line. Each line has its own rising-edge enable and falling-edge enable. A detected edge sets that line's pending flag. The interrupt output for a line is its pending flag gated by its mask bit.

Software sets up and services the block through a small register bus. The bus has eight word addresses:

| Address | Contents |
|---|---|
| 0 to 3 | The port-select codes, four line fields per word |
| 4 | Rising-edge enables |
| 5 | Falling-edge enables |
| 6 | Interrupt mask |
| 7 | Pending flags |

A handler reads the pending word, services its source, and clears the flag by writing 1 to that bit.

Writing a new code for a line replaces the old one. Two ports are never merged onto one line. The pin that was selected before stops triggering as soon as the new code is written.

Top module: `exti_portsel`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq_out` is 0. This means every line selects port code 0, no trigger is enabled, every line is masked and nothing is pending.
- R2: The select code for line n sits at bits [4*(n%4)+3 : 4*(n%4)] of the select word at address n/4. Code p in the range 0 to 6 makes the line watch input `port_pins[p*16+n]`.
- R3: Writing a new code into a line's field replaces the old one. After the write, edges on the previously selected pin no longer set that line's pending flag.
- R4: Codes 7 to 15 select a constant-low input. Edges on pin n of any port then never set pending bit n.
- R5: A 0-to-1 change of the selected pin sets pending bit n when bit n of the rising word (address 4) is 1. A 1-to-0 change sets it when bit n of the falling word (address 5) is 1. With both bits set, either change sets it. With neither set, no change sets it.
- R6: Suppose a pin change is first sampled at clock edge k. The pending bit and the gated `irq_out` bit then become 1 at edge k+2, and not earlier.
- R7: Writing the pending word (address 7) clears each bit written as 1 and leaves the bits written as 0 unchanged. If an edge on a line arrives in the same cycle that its clear is written, the bit stays 1.
- R8: `irq_out[n]` equals pending bit n AND mask bit n (address 6, 1 = enabled). Pending bits still set while their line is masked.
- R9: Changing a line's select code does not set its pending flag, even when the old and new pins differ in level.
- R10: Every register reads back what was written to it. `bus_rdata` shows the word at `bus_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | 112 | Asynchronous pins; port p, pin n at bit p*16+n |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for `bus_addr` |
| irq_out | output | 16 | Per-line interrupt requests, registered |

## Verification
The hardest situation to bring about is a clear that lands in exactly the cycle a new edge reaches a line. The bench counts the synchronizer stages from the negative clock edge at which it moves a pin. It then raises the write-1 strobe in the cycle that ends at edge k+2.

It uses the same counting to watch `irq_out` stay low after edge k+1 and go high after edge k+2. The bench also switches a line between two pins held at opposite levels, which shows that a change of selection creates no edge. It then moves a port the line no longer selects.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEL0 = 3'd0,
    A_SEL1 = 3'd1,
    A_SEL2 = 3'd2,
    A_SEL3 = 3'd3,
    A_RISE = 3'd4,
    A_FALL = 3'd5,
    A_MASK = 3'd6,
    A_PEND = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/exti_regs.sv
module exti_regs
  import exti_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [NUM_LINES-1:0]       pend_i,
  output logic [NUM_LINES*SEL_W-1:0] sel_o,
  output logic [NUM_LINES-1:0]       rise_o,
  output logic [NUM_LINES-1:0]       fall_o,
  output logic [NUM_LINES-1:0]       mask_o,
  output logic [NUM_LINES-1:0]       mask_d_o,
  output logic [DATA_W-1:0]          rdata_o
);
  localparam int FIELDS   = DATA_W / SEL_W;
  localparam int SEL_REGS = NUM_LINES / FIELDS;
  localparam int SR_W     = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1;

  logic [DATA_W-1:0]    sel_q [SEL_REGS];
  logic [NUM_LINES-1:0] rise_q, fall_q, mask_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 is_sel;

  assign is_sel = (32'(bus_addr) < SEL_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < SEL_REGS; r++) sel_q[r] <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (is_sel) sel_q[bus_addr[SR_W-1:0]] <= bus_wdata;
      if (bus_addr == A_RISE) rise_q <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == A_FALL) fall_q <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == A_MASK) mask_q <= bus_wdata[NUM_LINES-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (is_sel) begin
      rdata_q <= sel_q[bus_addr[SR_W-1:0]];
    end else begin
      case (bus_addr)
        A_RISE:  rdata_q <= DATA_W'(rise_q);
        A_FALL:  rdata_q <= DATA_W'(fall_q);
        A_MASK:  rdata_q <= DATA_W'(mask_q);
        A_PEND:  rdata_q <= DATA_W'(pend_i);
        default: rdata_q <= '0;
      endcase
    end
  end

  for (genvar r = 0; r < SEL_REGS; r++) begin : g_sel_flat
    assign sel_o[r*DATA_W +: DATA_W] = sel_q[r];
  end

  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign mask_o   = mask_q;
  assign mask_d_o = (bus_wr && bus_addr == A_MASK) ? bus_wdata[NUM_LINES-1:0] : mask_q;
  assign rdata_o  = rdata_q;

  // R10
  mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MASK) |=> (mask_q == $past(bus_wdata[NUM_LINES-1:0])));
endmodule

// File: rtl/exti_edge.sv
module exti_edge
  import exti_pkg::*;
#(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pins_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 rise_en,
  input  logic                 fall_en,
  output logic                 edge_o
);
  localparam int CODES = 2 ** SEL_W;

  logic [CODES-1:0] padded;
  logic             cur;
  logic             prev_q;
  logic [SEL_W-1:0] sel_last_q;
  logic             same_sel;

  assign padded   = CODES'(pins_i);
  assign cur      = padded[sel_i];
  assign same_sel = (sel_i == sel_last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= 1'b0;
      sel_last_q <= '0;
    end else begin
      prev_q     <= cur;
      sel_last_q <= sel_i;
    end
  end

  assign edge_o = same_sel & ((rise_en & cur & ~prev_q) | (fall_en & ~cur & prev_q));

  // R9
  no_sel_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i != $past(sel_i)) |-> !edge_o);
  // R5
  trig_en_chk: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> (rise_en || fall_en));
  // R4
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((32'(sel_i) >= NUM_PORTS) && $stable(sel_i)) |-> !edge_o);
endmodule

// File: rtl/exti_portsel.sv
module exti_portsel
  import exti_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 7,
  parameter int DATA_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_LINES-1:0]           irq_out
);
  localparam int NPINS = NUM_PORTS * NUM_LINES;

  logic [NPINS-1:0]           pins_s;
  logic [NUM_LINES*SEL_W-1:0] sel;
  logic [NUM_LINES-1:0]       rise, fall, mask_q, mask_d;
  logic [NUM_LINES-1:0]       edge_v, clr, pend_q, pend_d, irq_q;

  exti_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (port_pins),
    .q_o (pins_s)
  );

  exti_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_i    (pend_q),
    .sel_o     (sel),
    .rise_o    (rise),
    .fall_o    (fall),
    .mask_o    (mask_q),
    .mask_d_o  (mask_d),
    .rdata_o   (bus_rdata)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] line_pins;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign line_pins[p] = pins_s[p*NUM_LINES + n];
    end
    exti_edge #(.NUM_PORTS(NUM_PORTS)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .pins_i  (line_pins),
      .sel_i   (sel[n*SEL_W +: SEL_W]),
      .rise_en (rise[n]),
      .fall_en (fall[n]),
      .edge_o  (edge_v[n])
    );
  end

  assign clr    = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign pend_d = (pend_q & ~clr) | edge_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d & mask_d;
    end
  end

  assign irq_out = irq_q;

  // R7
  clr_only_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_v != '0) |=> ((pend_q & $past(edge_v)) == $past(edge_v)));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~mask_q) == '0) && ((irq_out & ~pend_q) == '0));
endmodule

// File: tb/exti_portsel_tb.sv
module exti_portsel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int NP = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NP*NL-1:0] pins = '0;
  logic           bus_wr = 1'b0;
  logic [2:0]     bus_addr = '0;
  logic [15:0]    bus_wdata = '0;
  logic [15:0]    bus_rdata;
  logic [15:0]    irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] rd;

  exti_portsel u_dut (
    .clk (clk), .rst (rst), .port_pins (pins),
    .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq_out (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {line[12:9], code[8:5], rise[4], fall[3], start[2], end[1], expect[0]}
  localparam logic [12:0] VEC [10] = '{
    {4'd1,  4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd1,  4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd0,  4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd0,  4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd15, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd15, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd7,  4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9,  4'd8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd12, 4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd4,  4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int r = 0; r < 4; r++) wr(3'(r), 16'h0);
    wr(3'd4, 16'h0); wr(3'd5, 16'h0); wr(3'd7, 16'hFFFF);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", irq_out, 16'h0);
    for (int a = 0; a < 8; a++) begin
      rdreg(3'(a), rd);
      check("R1 reg", rd, 16'h0);
    end

    // R10: readback
    wr(3'd6, 16'hA5C3); rdreg(3'd6, rd); check("R10 mask", rd, 16'hA5C3);
    wr(3'd2, 16'h1234); rdreg(3'd2, rd); check("R10 sel2", rd, 16'h1234);
    wr(3'd6, 16'hFFFF);

    // Vector table: R2 R4 R5 R8
    for (int i = 0; i < 10; i++) begin
      automatic logic [12:0] v = VEC[i];
      automatic int ln = int'(v[12:9]);
      automatic int code = int'(v[8:5]);
      clear_all();
      pins = {(NP*NL){v[2]}};
      wr(3'(ln/4), 16'(code << (4*(ln%4))));
      wr(3'd4, 16'(v[4]) << ln);
      wr(3'd5, 16'(v[3]) << ln);
      idle(4);
      wr(3'd7, 16'hFFFF);
      if (code < NP) pins[code*NL + ln] = v[1];
      else for (int p = 0; p < NP; p++) pins[p*NL + ln] = v[1];
      idle(4);
      rdreg(3'd7, rd);
      check("R2/R4/R5 pend", rd, 16'(v[0]) << ln);
      check("R8 irq", irq_out, 16'(v[0]) << ln);
    end

    // R3: overwrite of selection
    clear_all();
    pins = '1;
    wr(3'd0, 16'h0060); wr(3'd5, 16'h0002);
    wr(3'd0, 16'h0050);
    idle(4); wr(3'd7, 16'hFFFF);
    pins[6*NL + 1] = 1'b0; idle(4);
    rdreg(3'd7, rd); check("R3 old pin", rd, 16'h0);
    pins[5*NL + 1] = 1'b0; idle(4);
    rdreg(3'd7, rd); check("R3 new pin", rd, 16'h0002);

    // R9: select change between pins of opposite level
    clear_all();
    pins = '0;
    pins[1*NL + 2] = 1'b1;
    wr(3'd4, 16'h0004); wr(3'd5, 16'h0004);
    idle(4); wr(3'd7, 16'hFFFF);
    wr(3'd0, 16'h0100); idle(4);
    rdreg(3'd7, rd); check("R9 no false edge", rd, 16'h0);
    pins[0*NL + 2] = 1'b1; idle(4);
    rdreg(3'd7, rd); check("R9 deselected port", rd, 16'h0);

    // R6: latency, line 3 port A rising
    clear_all();
    pins = '0;
    wr(3'd4, 16'h0008);
    idle(4); wr(3'd7, 16'hFFFF);
    pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 early", irq_out, 16'h0);
    @(negedge clk);
    check("R6 on time", irq_out, 16'h0008);

    // R7: writing 0 leaves bit, writing 1 clears
    wr(3'd7, 16'h0000); rdreg(3'd7, rd); check("R7 write0", rd, 16'h0008);
    wr(3'd7, 16'h0008); rdreg(3'd7, rd); check("R7 write1", rd, 16'h0);

    // R7: edge in same cycle as clear
    pins[3] = 1'b0; idle(4);
    wr(3'd7, 16'h0008);
    pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 16'h0008;
    @(negedge clk);
    bus_wr = 1'b0;
    rdreg(3'd7, rd); check("R7 edge wins", rd, 16'h0008);

    // R8: pending sets while masked, irq follows mask
    clear_all();
    wr(3'd6, 16'h0000);
    pins = '0;
    wr(3'd4, 16'h0001);
    idle(4); wr(3'd7, 16'hFFFF);
    pins[0] = 1'b1; idle(4);
    check("R8 masked irq", irq_out, 16'h0);
    rdreg(3'd7, rd); check("R8 masked pend", rd, 16'h0001);
    wr(3'd6, 16'h0001);
    check("R8 unmask irq", irq_out, 16'h0001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule